// File: doc/BRIEF.md
# Shared Cell Buffer Queue Manager

This block owns a byte-organised cell store shared between a byte-wide cell link and a local processor. The store holds `NUM_SLOTS` cell slots of `CELL_BYTES` bytes each. The lower half of the slots forms the receive region. An arriving cell is written into a free receive slot, and that slot joins a ready queue in arrival order. The processor sees the head of that queue and pops it when it takes the cell. It then works on the bytes in place through a random-access port. When it has finished, it does one of two things:
- It hands the slot back to the free pool with an explicit release.
- It threads the slot onto the transmit queue. A single write does this and no payload is copied.

The transmit queue accepts any slot of the store. This includes the upper slots, which the processor fills itself. A byte-serial engine drains the transmit queue onto the outgoing link. A receive slot that has been sent returns to the free pool by itself.

Both link directions are valid/ready streams that move one byte per accepted clock, with a start-of-cell flag on byte 0:
- **Receive side.** `rx_ready` is low only between cells, and only when no free receive slot exists. The sender must then hold its cell, so cells stall rather than being dropped. Once a cell has started, `rx_ready` stays high until its last byte.
- **Transmit side.** `tx_data` and `tx_sop` are held while `tx_valid` is high and `tx_ready` is low.

Top module: `cbq_cell_queue_mgr`

## Requirements
- R1: After reset, the free pool holds every receive slot (0 to `NUM_SLOTS/2-1`, handed out in ascending order). The ready and transmit queues are empty, `tx_valid` is low and `free_full` is high.
- R2: When idle, an accepted byte with `rx_sop` high starts a cell. The cell is stored into the slot at the head of the free pool, at byte offsets 0 to `CELL_BYTES-1` in arrival order. While a cell is in progress, `rx_sop` is treated as data.
- R3: The cycle after a cell's last byte is accepted, its slot appears in the ready queue. `rdy_slot` shows the oldest complete cell. `rdy_pop` removes it, and `rdyq_full` is high when every receive slot waits there.
- R4: Between cells with no free slot, `rx_ready` is low. A sender holding `rx_valid` then stalls without loss. Inside a cell, `rx_ready` stays high.
- R5: A receive slot is never reissued until it has been released or transmitted. A release appends it to the tail of the free pool.
- R6: A release with `rel_slot` of `NUM_SLOTS/2` or above has no effect.
- R7: Transmit-queue entries are sent in queue order as `CELL_BYTES` bytes read from the named slot. `tx_sop` is high on byte 0 only, and `tx_data`/`tx_sop` are held while `tx_ready` is low.
- R8: After the last byte of a receive slot is sent, that slot is appended to the free pool. A slot of the upper half is not.
- R9: The transmit queue holds `NUM_SLOTS` entries plus the one in flight. `txq_push` while `txq_full` is high is ignored.
- R10: A release and a transmit completion in the same cycle both return their slots to the free pool.
- R11: A processor read (`cpu_en` high, `cpu_we` low) returns the addressed byte on `cpu_rdata` the next cycle. A processor write changes the byte seen by later reads and transmissions.
- R12: Bytes accepted between cells without `rx_sop` are discarded and do not start a cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_sop | input | 1 | Receive byte is byte 0 of a cell |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Block accepts the receive byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_sop | output | 1 | Transmit byte is byte 0 of a cell |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Link accepts the transmit byte |
| cpu_en | input | 1 | Processor store access enable |
| cpu_we | input | 1 | Processor access is a write |
| cpu_slot | input | 3 | Processor slot index |
| cpu_byte | input | 6 | Processor byte offset in slot |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Processor read byte, one cycle after the request |
| rdy_valid | output | 1 | A complete received cell waits |
| rdy_slot | output | 3 | Slot of the oldest waiting cell |
| rdy_pop | input | 1 | Processor takes the waiting cell |
| rel_valid | input | 1 | Release a receive slot |
| rel_slot | input | 3 | Slot to release |
| txq_push | input | 1 | Append a slot to the transmit queue |
| txq_slot | input | 3 | Slot to transmit |
| free_empty | output | 1 | No free receive slot |
| free_full | output | 1 | Every receive slot is free |
| rdyq_full | output | 1 | Ready queue full |
| txq_empty | output | 1 | Transmit queue empty |
| txq_full | output | 1 | Transmit queue full |

## Verification
The free pool has two writers. A processor release and the transmit engine's return of a finished receive slot can land on the same clock edge. Both entries must be stored. The bench provokes this by timing a release onto the exact cycle in which it hands the last byte of a queued receive slot to the link. It then judges the result at the ports: `free_full` must rise, which it cannot do if either return was lost.

// File: rtl/cbq_pkg.sv
package cbq_pkg;
  // engine activity state shared by the receive and transmit sequencers
  typedef enum logic {
    ENG_IDLE   = 1'b0,
    ENG_ACTIVE = 1'b1
  } eng_state_t;
endpackage

// File: rtl/cbq_slot_fifo.sv
module cbq_slot_fifo #(
  parameter int DEPTH   = 4,
  parameter int IW      = 3,
  parameter bit PRELOAD = 1'b0,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_a,
  input  logic [IW-1:0] din_a,
  input  logic          push_b,
  input  logic [IW-1:0] din_b,
  input  logic          pop,
  output logic [IW-1:0] head,
  output logic [CW-1:0] count
);
  logic [IW-1:0] store [DEPTH];
  logic [PW-1:0] rd_p, wr_p, wr_p_b;
  logic [CW-1:0] cnt;
  logic          is_full, take_a, take_b, take_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign is_full  = (cnt == CW'(DEPTH));
  assign take_a   = push_a && !is_full;
  // second writer lands behind the first; space is judged before any pop
  assign take_b   = push_b && ((cnt + CW'(take_a)) < CW'(DEPTH));
  assign take_pop = pop && (cnt != '0);
  assign wr_p_b   = take_a ? step(wr_p) : wr_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= PRELOAD ? CW'(DEPTH) : '0;
      for (int i = 0; i < DEPTH; i++) begin
        store[i] <= PRELOAD ? IW'(i) : '0;
      end
    end else begin
      if (take_a) store[wr_p] <= din_a;
      if (take_b) store[wr_p_b] <= din_b;
      if (take_pop) rd_p <= step(rd_p);
      wr_p <= take_b ? step(wr_p_b) : wr_p_b;
      cnt  <= cnt + CW'(take_a) + CW'(take_b) - CW'(take_pop);
    end
  end

  assign head  = store[rd_p];
  assign count = cnt;
endmodule

// File: rtl/cbq_cell_mem.sv
module cbq_cell_mem #(
  parameter int NUM_SLOTS  = 8,
  parameter int CELL_BYTES = 53,
  localparam int DEPTH = NUM_SLOTS * CELL_BYTES,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  // link side write (receive engine)
  input  logic          lw_en,
  input  logic [AW-1:0] lw_addr,
  input  logic [7:0]    lw_data,
  // link side read (transmit engine), combinational
  input  logic [AW-1:0] lr_addr,
  output logic [7:0]    lr_data,
  // processor side, registered read
  input  logic          cp_en,
  input  logic          cp_we,
  input  logic [AW-1:0] cp_addr,
  input  logic [7:0]    cp_wdata,
  output logic [7:0]    cp_rdata
);
  logic [7:0] bytes_q [DEPTH];
  logic       cp_wr_ok;

  // the link write wins a same-address collision; other processor writes proceed
  assign cp_wr_ok = cp_en && cp_we && !(lw_en && (lw_addr == cp_addr));

  always_ff @(posedge clk) begin
    if (lw_en) bytes_q[lw_addr] <= lw_data;
    if (cp_wr_ok) bytes_q[cp_addr] <= cp_wdata;
    if (cp_en && !cp_we) cp_rdata <= bytes_q[cp_addr];
  end

  assign lr_data = bytes_q[lr_addr];
endmodule

// File: rtl/cbq_rx_engine.sv
module cbq_rx_engine
  import cbq_pkg::*;
#(
  parameter int NUM_SLOTS  = 8,
  parameter int CELL_BYTES = 53,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int BW = $clog2(CELL_BYTES),
  localparam int AW = $clog2(NUM_SLOTS * CELL_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic          rx_sop,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  input  logic          pool_empty,
  input  logic [SW-1:0] pool_head,
  output logic          pool_take,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          done_push,
  output logic [SW-1:0] done_slot
);
  eng_state_t    st;
  logic [SW-1:0] cur_slot_q;
  logic [BW-1:0] idx_q;
  logic          fire, start, active, last;
  logic [SW-1:0] slot_now;
  logic [BW-1:0] idx_now;

  assign active    = (st == ENG_ACTIVE);
  assign rx_ready  = active || !pool_empty;
  assign fire      = rx_valid && rx_ready;
  assign start     = fire && !active && rx_sop;
  assign last      = fire && active && (idx_q == BW'(CELL_BYTES - 1));
  assign pool_take = start;

  assign slot_now  = active ? cur_slot_q : pool_head;
  assign idx_now   = active ? idx_q : '0;
  assign wr_en     = start || (fire && active);
  assign wr_addr   = AW'(slot_now) * AW'(CELL_BYTES) + AW'(idx_now);
  assign wr_data   = rx_data;
  assign done_push = last;
  assign done_slot = cur_slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ENG_IDLE;
      cur_slot_q <= '0;
      idx_q      <= '0;
    end else if (start) begin
      st         <= ENG_ACTIVE;
      cur_slot_q <= pool_head;
      idx_q      <= BW'(1);
    end else if (fire && active) begin
      if (last) st <= ENG_IDLE;
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/cbq_tx_engine.sv
module cbq_tx_engine
  import cbq_pkg::*;
#(
  parameter int NUM_SLOTS  = 8,
  parameter int CELL_BYTES = 53,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int BW = $clog2(CELL_BYTES),
  localparam int AW = $clog2(NUM_SLOTS * CELL_BYTES),
  localparam int RX_SLOTS = NUM_SLOTS / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_empty,
  input  logic [SW-1:0] q_head,
  output logic          q_take,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          tx_valid,
  output logic          tx_sop,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  output logic          fin_push,
  output logic [SW-1:0] fin_slot
);
  eng_state_t    st;
  logic [SW-1:0] slot_q;
  logic [BW-1:0] idx_q;
  logic          active, fire, last;

  assign active   = (st == ENG_ACTIVE);
  assign q_take   = !active && !q_empty;
  assign fire     = active && tx_ready;
  assign last     = fire && (idx_q == BW'(CELL_BYTES - 1));

  assign rd_addr  = AW'(slot_q) * AW'(CELL_BYTES) + AW'(idx_q);
  assign tx_valid = active;
  assign tx_sop   = active && (idx_q == '0);
  assign tx_data  = rd_data;
  // only receive-region slots go back to the pool
  assign fin_push = last && (slot_q < SW'(RX_SLOTS));
  assign fin_slot = slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ENG_IDLE;
      slot_q <= '0;
      idx_q  <= '0;
    end else if (q_take) begin
      st     <= ENG_ACTIVE;
      slot_q <= q_head;
      idx_q  <= '0;
    end else if (fire) begin
      if (last) st <= ENG_IDLE;
      idx_q <= last ? '0 : idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/cbq_cell_queue_mgr.sv
module cbq_cell_queue_mgr #(
  parameter int NUM_SLOTS  = 8,
  parameter int CELL_BYTES = 53,
  localparam int SW       = $clog2(NUM_SLOTS),
  localparam int BW       = $clog2(CELL_BYTES),
  localparam int AW       = $clog2(NUM_SLOTS * CELL_BYTES),
  localparam int RX_SLOTS = NUM_SLOTS / 2,
  localparam int FCW      = $clog2(RX_SLOTS + 1),
  localparam int TCW      = $clog2(NUM_SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic          rx_sop,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic          tx_sop,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  input  logic          cpu_en,
  input  logic          cpu_we,
  input  logic [SW-1:0] cpu_slot,
  input  logic [BW-1:0] cpu_byte,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  output logic          rdy_valid,
  output logic [SW-1:0] rdy_slot,
  input  logic          rdy_pop,
  input  logic          rel_valid,
  input  logic [SW-1:0] rel_slot,
  input  logic          txq_push,
  input  logic [SW-1:0] txq_slot,
  output logic          free_empty,
  output logic          free_full,
  output logic          rdyq_full,
  output logic          txq_empty,
  output logic          txq_full
);
  logic [FCW-1:0] free_cnt, rdy_cnt;
  logic [TCW-1:0] txq_cnt;
  logic [SW-1:0]  free_head, txq_head, done_slot, tx_fin_slot;
  logic           free_pop, done_push, tx_fin_push, rel_push, txq_take;
  logic           lw_en;
  logic [AW-1:0]  lw_addr, lr_addr, cp_addr;
  logic [7:0]     lw_data, lr_data;

  assign rel_push = rel_valid && (rel_slot < SW'(RX_SLOTS));
  assign cp_addr  = AW'(cpu_slot) * AW'(CELL_BYTES) + AW'(cpu_byte);

  // free receive slots; preloaded with every receive slot in ascending order
  cbq_slot_fifo #(.DEPTH(RX_SLOTS), .IW(SW), .PRELOAD(1'b1)) u_free (
    .clk(clk), .rst_n(rst_n),
    .push_a(rel_push), .din_a(rel_slot),
    .push_b(tx_fin_push), .din_b(tx_fin_slot),
    .pop(free_pop), .head(free_head), .count(free_cnt)
  );

  // complete received cells awaiting the processor
  cbq_slot_fifo #(.DEPTH(RX_SLOTS), .IW(SW), .PRELOAD(1'b0)) u_ready (
    .clk(clk), .rst_n(rst_n),
    .push_a(done_push), .din_a(done_slot),
    .push_b(1'b0), .din_b('0),
    .pop(rdy_pop), .head(rdy_slot), .count(rdy_cnt)
  );

  // slots queued for transmission, from anywhere in the store
  cbq_slot_fifo #(.DEPTH(NUM_SLOTS), .IW(SW), .PRELOAD(1'b0)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push_a(txq_push), .din_a(txq_slot),
    .push_b(1'b0), .din_b('0),
    .pop(txq_take), .head(txq_head), .count(txq_cnt)
  );

  cbq_cell_mem #(.NUM_SLOTS(NUM_SLOTS), .CELL_BYTES(CELL_BYTES)) u_mem (
    .clk(clk),
    .lw_en(lw_en), .lw_addr(lw_addr), .lw_data(lw_data),
    .lr_addr(lr_addr), .lr_data(lr_data),
    .cp_en(cpu_en), .cp_we(cpu_we), .cp_addr(cp_addr),
    .cp_wdata(cpu_wdata), .cp_rdata(cpu_rdata)
  );

  cbq_rx_engine #(.NUM_SLOTS(NUM_SLOTS), .CELL_BYTES(CELL_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_data(rx_data), .rx_ready(rx_ready),
    .pool_empty(free_empty), .pool_head(free_head), .pool_take(free_pop),
    .wr_en(lw_en), .wr_addr(lw_addr), .wr_data(lw_data),
    .done_push(done_push), .done_slot(done_slot)
  );

  cbq_tx_engine #(.NUM_SLOTS(NUM_SLOTS), .CELL_BYTES(CELL_BYTES)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .q_empty(txq_empty), .q_head(txq_head), .q_take(txq_take),
    .rd_addr(lr_addr), .rd_data(lr_data),
    .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_data(tx_data), .tx_ready(tx_ready),
    .fin_push(tx_fin_push), .fin_slot(tx_fin_slot)
  );

  assign free_empty = (free_cnt == '0);
  assign free_full  = (free_cnt == FCW'(RX_SLOTS));
  assign rdy_valid  = (rdy_cnt != '0);
  assign rdyq_full  = (rdy_cnt == FCW'(RX_SLOTS));
  assign txq_empty  = (txq_cnt == '0);
  assign txq_full   = (txq_cnt == TCW'(NUM_SLOTS));
endmodule

// File: rtl/cbq_cell_queue_chk.sv
module cbq_cell_queue_chk #(
  parameter int NUM_SLOTS = 8,
  localparam int SW       = $clog2(NUM_SLOTS),
  localparam int RX_SLOTS = NUM_SLOTS / 2,
  localparam int FCW      = $clog2(RX_SLOTS + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rx_valid,
  input logic           rx_sop,
  input logic           rx_ready,
  input logic           tx_valid,
  input logic           tx_ready,
  input logic           tx_sop,
  input logic           rel_valid,
  input logic [SW-1:0]  rel_slot,
  input logic           free_empty,
  input logic           free_full,
  input logic           free_pop,
  input logic           rel_push,
  input logic           tx_fin_push,
  input logic [FCW-1:0] free_cnt
);
  // R4
  rx_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> free_empty);

  // R2
  rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && rx_sop && free_full |=> !free_full);

  // R6
  bad_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_empty && rel_valid && (rel_slot >= SW'(RX_SLOTS)) && !tx_fin_push |=> free_empty);

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_sop));

  // R7
  tx_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_sop |=> !tx_sop);

  // R10
  dual_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_push && tx_fin_push |=>
      int'(free_cnt) == int'($past(free_cnt)) + 2 - int'($past(free_pop)));
endmodule

bind cbq_cell_queue_mgr cbq_cell_queue_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_sop(tx_sop),
  .rel_valid(rel_valid), .rel_slot(rel_slot),
  .free_empty(free_empty), .free_full(free_full),
  .free_pop(free_pop), .rel_push(rel_push),
  .tx_fin_push(tx_fin_push), .free_cnt(free_cnt)
);

// File: tb/cbq_cell_queue_mgr_tb_top.sv
module cbq_cell_queue_mgr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS  = 8;
  localparam int CB  = 53;
  localparam int RXS = NS / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_sop = 1'b0, rx_ready;
  logic [7:0] rx_data = '0;
  logic tx_valid, tx_sop, tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic cpu_en = 1'b0, cpu_we = 1'b0;
  logic [2:0] cpu_slot = '0;
  logic [5:0] cpu_byte = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic rdy_valid, rdy_pop = 1'b0;
  logic [2:0] rdy_slot;
  logic rel_valid = 1'b0, txq_push = 1'b0;
  logic [2:0] rel_slot = '0, txq_slot = '0;
  logic free_empty, free_full, rdyq_full, txq_empty, txq_full;

  int n_checks = 0;
  int n_fail = 0;
  int free_q[$];
  int rdy_q[$];
  int tx_q[$];
  logic [7:0] mem_m [NS][CB];

  always #(CLK_PERIOD / 2) clk = ~clk;

  cbq_cell_queue_mgr #(.NUM_SLOTS(NS), .CELL_BYTES(CB)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_data(tx_data), .tx_ready(tx_ready),
    .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_slot(cpu_slot), .cpu_byte(cpu_byte),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .rdy_valid(rdy_valid), .rdy_slot(rdy_slot), .rdy_pop(rdy_pop),
    .rel_valid(rel_valid), .rel_slot(rel_slot),
    .txq_push(txq_push), .txq_slot(txq_slot),
    .free_empty(free_empty), .free_full(free_full), .rdyq_full(rdyq_full),
    .txq_empty(txq_empty), .txq_full(txq_full)
  );

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_free_empty();
    return free_q.size() == 0;
  endfunction

  function automatic bit exp_free_full();
    return free_q.size() == RXS;
  endfunction

  // flags and ready head against the model; called at a negedge with tx idle
  task automatic check_flags(input string req);
    chk(free_empty == exp_free_empty(), req, free_empty, exp_free_empty());
    chk(free_full == exp_free_full(), req, free_full, exp_free_full());
    chk(rdy_valid == (rdy_q.size() > 0), req, rdy_valid, rdy_q.size() > 0);
    chk(rdyq_full == (rdy_q.size() == RXS), req, rdyq_full, rdy_q.size() == RXS);
    if (rdy_q.size() > 0) chk(rdy_slot == rdy_q[0], "R3", rdy_slot, rdy_q[0]);
  endtask

  task automatic send_cell(input bit stray);
    int s;
    bit acc;
    s = free_q.pop_front();
    for (int i = 0; i < CB; i++) mem_m[s][i] = 8'($urandom);
    if (stray) begin
      // R12: byte between cells without a start flag
      do begin
        @(negedge clk);
        rx_valid = 1'b1; rx_sop = 1'b0; rx_data = 8'hA5;
        acc = rx_ready;
        @(posedge clk);
      end while (!acc);
    end
    for (int i = 0; i < CB; i++) begin
      if ($urandom_range(3) == 0) begin
        @(negedge clk);
        rx_valid = 1'b0;
        @(posedge clk);
      end
      do begin
        @(negedge clk);
        rx_valid = 1'b1; rx_sop = (i == 0); rx_data = mem_m[s][i];
        acc = rx_ready;
        if (i > 0) chk(acc, "R4", acc, 1);
        @(posedge clk);
      end while (!acc);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0;
    rdy_q.push_back(s);
  endtask

  task automatic pop_rdy(output int s);
    @(negedge clk);
    chk(rdy_valid, "R3", rdy_valid, 1);
    chk(rdy_slot == rdy_q[0], "R3", rdy_slot, rdy_q[0]);
    rdy_pop = 1'b1;
    @(negedge clk);
    rdy_pop = 1'b0;
    s = rdy_q.pop_front();
  endtask

  task automatic release_slot(input int s);
    @(negedge clk);
    rel_valid = 1'b1; rel_slot = 3'(s);
    @(negedge clk);
    rel_valid = 1'b0;
    if (s < RXS) free_q.push_back(s);
  endtask

  task automatic cpu_wr(input int s, input int b, input logic [7:0] v);
    @(negedge clk);
    cpu_en = 1'b1; cpu_we = 1'b1; cpu_slot = 3'(s); cpu_byte = 6'(b); cpu_wdata = v;
    @(negedge clk);
    cpu_en = 1'b0; cpu_we = 1'b0;
    mem_m[s][b] = v;
  endtask

  task automatic cpu_rd_chk(input int s, input int b, input string req);
    @(negedge clk);
    cpu_en = 1'b1; cpu_we = 1'b0; cpu_slot = 3'(s); cpu_byte = 6'(b);
    @(negedge clk);
    cpu_en = 1'b0;
    chk(cpu_rdata == mem_m[s][b], req, cpu_rdata, mem_m[s][b]);
  endtask

  task automatic push_tx(input int s, input bit expect_taken);
    @(negedge clk);
    txq_push = 1'b1; txq_slot = 3'(s);
    @(negedge clk);
    txq_push = 1'b0;
    if (expect_taken) tx_q.push_back(s);
  endtask

  // drain cells from the model queue; rel_s >= 0 releases that slot on the final byte
  task automatic drain_tx(input int ncell, input int rel_s);
    int s;
    bit acc;
    for (int c = 0; c < ncell; c++) begin
      s = tx_q.pop_front();
      for (int i = 0; i < CB; i++) begin
        do begin
          @(negedge clk);
          tx_ready = ($urandom_range(3) != 0);
          if (rel_s >= 0 && c == ncell - 1 && i == CB - 1 && tx_valid) begin
            tx_ready = 1'b1;
            rel_valid = 1'b1; rel_slot = 3'(rel_s);
          end
          acc = tx_valid && tx_ready;
          if (acc) begin
            chk(tx_data == mem_m[s][i], "R7", tx_data, mem_m[s][i]);
            chk(tx_sop == (i == 0), "R7", tx_sop, i == 0);
          end
          @(posedge clk);
        end while (!acc);
      end
      if (rel_s >= 0 && c == ncell - 1) free_q.push_back(rel_s);
      if (s < RXS) free_q.push_back(s);
    end
    @(negedge clk);
    tx_ready = 1'b0; rel_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int s, t;
    void'($urandom(32'd4242));
    for (int i = 0; i < RXS; i++) free_q.push_back(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(rx_ready == 1'b1, "R1", rx_ready, 1);
    chk(tx_valid == 1'b0, "R1", tx_valid, 0);
    chk(free_full == 1'b1, "R1", free_full, 1);
    chk(free_empty == 1'b0, "R1", free_empty, 0);
    chk(rdy_valid == 1'b0, "R1", rdy_valid, 0);
    chk(txq_empty == 1'b1, "R1", txq_empty, 1);
    chk(txq_full == 1'b0, "R1", txq_full, 0);

    // R2 / R11: first cell lands in slot 0
    send_cell(1'b0);
    check_flags("R2");
    cpu_rd_chk(0, 0, "R2");
    cpu_rd_chk(0, CB - 1, "R2");
    cpu_rd_chk(0, 17, "R11");

    // R12: stray byte ahead of the next cell
    send_cell(1'b1);
    cpu_rd_chk(1, 0, "R12");
    cpu_rd_chk(1, 1, "R12");
    check_flags("R12");

    // R4: fill every receive slot, then a waiting sender must stall
    send_cell(1'b0);
    send_cell(1'b0);
    check_flags("R3");
    @(negedge clk);
    rx_valid = 1'b1; rx_sop = 1'b1; rx_data = 8'h3C;
    chk(rx_ready == 1'b0, "R4", rx_ready, 0);
    repeat (3) @(negedge clk);
    chk(rx_ready == 1'b0, "R4", rx_ready, 0);
    chk(free_empty == 1'b1, "R4", free_empty, 1);
    rx_valid = 1'b0; rx_sop = 1'b0;

    // R6: release of an upper-half slot changes nothing
    release_slot(6);
    @(negedge clk);
    chk(free_empty == 1'b1, "R6", free_empty, 1);
    chk(rx_ready == 1'b0, "R6", rx_ready, 0);

    // R5: explicit release makes slot 0 reusable
    pop_rdy(s);
    chk(s == 0, "R5", s, 0);
    release_slot(s);
    @(negedge clk);
    chk(rx_ready == 1'b1, "R5", rx_ready, 1);
    pop_rdy(t);
    send_cell(1'b0);
    cpu_rd_chk(0, 5, "R5");
    check_flags("R5");

    // R7 / R8: upper slot built by the processor, then held receive slot t
    for (int i = 0; i < CB; i++) cpu_wr(4, i, 8'($urandom));
    push_tx(4, 1'b1);
    push_tx(t, 1'b1);
    drain_tx(1, -1);
    check_flags("R8");
    drain_tx(1, -1);
    check_flags("R8");
    @(negedge clk);
    chk(txq_empty == 1'b1, "R7", txq_empty, 1);

    // R9: fill the transmit queue with the link stalled
    for (int sl = 5; sl < NS; sl++) begin
      for (int i = 0; i < CB; i++) cpu_wr(sl, i, 8'($urandom));
    end
    for (int k = 0; k < NS + 1; k++) push_tx(4 + (k % 4), 1'b1);
    @(negedge clk);
    chk(txq_full == 1'b1, "R9", txq_full, 1);
    push_tx(5, 1'b0);
    @(negedge clk);
    chk(txq_full == 1'b1, "R9", txq_full, 1);
    drain_tx(NS + 1, -1);
    repeat (3) @(negedge clk);
    chk(tx_valid == 1'b0, "R9", tx_valid, 0);
    chk(txq_empty == 1'b1, "R9", txq_empty, 1);

    // random mix of receive, release and in-place forwarding
    for (int it = 0; it < 40; it++) begin
      int op;
      op = $urandom_range(2);
      if (op == 0 && free_q.size() > 0) begin
        send_cell($urandom_range(3) == 0);
        cpu_rd_chk(rdy_q[rdy_q.size() - 1], $urandom_range(CB - 1), "R2");
      end else if (op == 1 && rdy_q.size() > 0) begin
        pop_rdy(s);
        release_slot(s);
      end else if (rdy_q.size() > 0) begin
        pop_rdy(s);
        cpu_wr(s, $urandom_range(CB - 1), 8'($urandom));
        push_tx(s, 1'b1);
        drain_tx(1, -1);
      end
      check_flags("R8");
    end

    // R10: release and transmit completion on the same edge
    while (rdy_q.size() > 0) begin
      pop_rdy(s);
      release_slot(s);
    end
    check_flags("R10");
    send_cell(1'b0);
    send_cell(1'b0);
    pop_rdy(s);
    pop_rdy(t);
    push_tx(t, 1'b1);
    drain_tx(1, s);
    @(negedge clk);
    chk(free_full == 1'b1, "R10", free_full, 1);
    check_flags("R10");

    summary();
  end
endmodule